// File: doc/BRIEF.md
# Backplane Address Window Manager

This block turns 32-bit backplane accesses from a host into the request stream a bus transaction engine expects. The engine can only reach the backplane through a 32 KB window. The upper part of every address therefore has to be loaded into three byte-wide window-base registers first. The access itself then goes out with the 15-bit offset inside that window.

The block keeps a copy of the window base it last programmed. Before each access it emits one register write for each window byte that differs from that copy, most significant byte first, and skips the bytes that already match. Single accesses of 1, 2 or 4 bytes go out as one request each; the 4-byte size is marked with a flag bit in the bus address. Bulk requests are cut into chunks. No chunk is larger than the maximum transfer size, and no chunk runs past the end of the current window. The window check runs again before every chunk. A misaligned bulk request is refused without any bus traffic.

Top module: `bpw_window_mgr`

## Requirements
- R1: After reset `req_ready` is 1, `eng_valid`, `done` and `err` are 0, and the remembered window base is 0xAAAAAAAA, so the first access only writes the window bytes that differ from that value.
- R2: A window byte write is a request with `eng_win`=1, `eng_func`=1, `eng_write`=1, `eng_len`=1 and the byte in `eng_wdata`. Address bits 31:24 go to bus address 0x1000C, bits 23:16 to 0x1000B and bits 15:8 to 0x1000A, and needed writes are issued in that order.
- R3: A window byte is written only when it differs from the remembered value, so an access in the same window as the previous one has no window writes.
- R4: An access request has `eng_win`=0, `eng_func`=1, `eng_write` equal to the host's `req_write`, and the low 15 bits of `eng_addr` equal to the current address ANDed with 0x7FFF.
- R5: `req_kind` 0, 1 and 2 mean single accesses of 1, 2 and 4 bytes, and `eng_len` carries that size. Only the 4-byte kind sets bit 15 (0x8000) of `eng_addr`. Bit 16 of `eng_addr` is always 0 for accesses.
- R6: With `req_kind`=3 (bulk), `req_len` bytes are transferred in chunks of 1 to MAX_CHUNK (default 64) bytes. The chunk addresses are consecutive and the chunk lengths add up to `req_len`.
- R7: No bulk chunk runs past the end of its 32 KB window. The window check runs again before every chunk.
- R8: A bulk request whose address is not a multiple of 4 produces a one-cycle `err` pulse one cycle after acceptance. It produces no engine request and leaves the remembered window unchanged.
- R9: `done` pulses for one cycle after the handshake of the last access of a request. A bulk request of length 0 gives `done` one cycle after acceptance, with no traffic. `done` and `err` are never high together.
- R10: While `eng_valid` is high and `eng_ready` is low, the engine request stays valid and unchanged.
- R11: `req_ready` is high only while no request is in progress, and never while `eng_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_kind | input | 2 | 0 byte, 1 half, 2 word, 3 bulk |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Backplane address |
| req_len | input | LEN_W | Bulk byte count |
| eng_valid | output | 1 | Engine request present |
| eng_ready | input | 1 | Engine takes request |
| eng_func | output | 2 | Function number (always 1) |
| eng_addr | output | 17 | Bus address |
| eng_len | output | LEN_W | Byte count of request |
| eng_write | output | 1 | Write direction |
| eng_win | output | 1 | Request is a window register write |
| eng_wdata | output | 8 | Window byte value |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Misaligned bulk rejected pulse |

## Verification
The bench sweeps bulk transfers that start just below a window end, with lengths on both sides of the 64-byte limit. A design that splits only by size would emit a chunk that straddles the window, and one that checks the window only once would skip the base write for the next window. Window byte writes are checked in order, and only for bytes that changed. The first access after reset is chosen so that the 0xAAAAAAAA start value leaves exactly one byte to write. A design that always writes all three bytes, or forgets the start value, fails here. The bench also covers the word flag on single accesses, misaligned and zero-length bulk requests, and random engine stalls that would expose a request changing while it waits.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

  typedef enum logic [1:0] {
    K_BYTE = 2'd0,
    K_HALF = 2'd1,
    K_WORD = 2'd2,
    K_BULK = 2'd3
  } bpw_kind_e;

  // window base: address with the offset bits cleared
  function automatic logic [31:0] win_base_f(input logic [31:0] a, input int wb);
    return a & ~((32'd1 << wb) - 32'd1);
  endfunction

  // offset inside the window
  function automatic logic [31:0] win_off_f(input logic [31:0] a, input int wb);
    return a & ((32'd1 << wb) - 32'd1);
  endfunction

  // chunk length limited by remaining bytes, max size and window room
  function automatic logic [31:0] chunk_f(input logic [31:0] rem, input logic [31:0] off,
                                          input logic [31:0] maxc, input logic [31:0] wsize);
    logic [31:0] m;
    m = rem;
    if (m > maxc) m = maxc;
    if (m > wsize - off) m = wsize - off;
    return m;
  endfunction

  function automatic logic [31:0] single_len_f(input bpw_kind_e k);
    case (k)
      K_BYTE:  return 32'd1;
      K_HALF:  return 32'd2;
      default: return 32'd4;
    endcase
  endfunction

endpackage

// File: rtl/bpw_win_regs.sv
module bpw_win_regs #(
  parameter int          N_BYTES = 3,
  parameter logic [31:0] INIT    = 32'hAAAA_AAAA,
  localparam int         IW      = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        target_base,
  input  logic               wr_fire,
  output logic [N_BYTES-1:0] diff,
  output logic               any_diff,
  output logic [IW-1:0]      pick_idx,
  output logic [7:0]         pick_val
);

  logic [8*N_BYTES-1:0] tgt_bytes;
  assign tgt_bytes = target_base[8 +: 8*N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [7:0] held;
    always_ff @(posedge clk) begin
      if (!rst_n)
        held <= INIT[8*(i+1) +: 8];
      else if (wr_fire && (pick_idx == IW'(i)))
        held <= tgt_bytes[8*i +: 8];
    end
    assign diff[i] = (held != tgt_bytes[8*i +: 8]);
  end

  assign any_diff = |diff;

  // highest differing byte first
  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < N_BYTES; i++)
      if (diff[i]) pick_idx = IW'(i);
  end

  assign pick_val = tgt_bytes[8*pick_idx +: 8];

  AST_WIN_WRITE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> any_diff); // R3

endmodule

// File: rtl/bpw_chunk_calc.sv
module bpw_chunk_calc
  import bpw_pkg::*;
#(
  parameter int WIN_BITS  = 15,
  parameter int MAX_CHUNK = 64,
  parameter int LEN_W     = 12,
  parameter int BUS_AW    = 17
) (
  input  logic [31:0]       cur_addr,
  input  logic [LEN_W-1:0]  rem,
  input  bpw_kind_e         kind,
  output logic [LEN_W-1:0]  acc_len,
  output logic [BUS_AW-1:0] acc_addr
);

  localparam logic [31:0] WIN_SIZE = 32'd1 << WIN_BITS;

  logic [31:0] off, len32, flag32, bus32;

  always_comb begin
    off    = win_off_f(cur_addr, WIN_BITS);
    len32  = (kind == K_BULK) ? chunk_f(32'(rem), off, 32'(MAX_CHUNK), WIN_SIZE)
                              : single_len_f(kind);
    flag32 = (kind == K_WORD) ? WIN_SIZE : 32'd0;
    bus32  = off | flag32;
  end

  assign acc_len  = len32[LEN_W-1:0];
  assign acc_addr = bus32[BUS_AW-1:0];

endmodule

// File: rtl/bpw_seq.sv
module bpw_seq
  import bpw_pkg::*;
#(
  parameter int              LEN_W        = 12,
  parameter int              BUS_AW       = 17,
  parameter int              IW           = 2,
  parameter logic [BUS_AW-1:0] WIN_REG_LO = 17'h1000A,
  parameter logic [1:0]      BP_FUNC      = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              eng_ready,
  input  logic              any_diff,
  input  logic [IW-1:0]     pick_idx,
  input  logic [7:0]        pick_val,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [BUS_AW-1:0] acc_addr,
  output logic [31:0]       cur_addr,
  output logic [LEN_W-1:0]  rem,
  output bpw_kind_e         kind,
  output logic              win_fire,
  output logic              acc_fire,
  output logic              eng_valid,
  output logic [1:0]        eng_func,
  output logic [BUS_AW-1:0] eng_addr,
  output logic [LEN_W-1:0]  eng_len,
  output logic              eng_write,
  output logic              eng_win,
  output logic [7:0]        eng_wdata,
  output logic              done,
  output logic              err
);

  typedef enum logic {S_IDLE, S_XFER} st_e;
  st_e  state;
  logic wr;
  logic accept, misaligned, empty_bulk, last_acc;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign misaligned = (bpw_kind_e'(req_kind) == K_BULK) && (req_addr[1:0] != 2'b00);
  assign empty_bulk = (bpw_kind_e'(req_kind) == K_BULK) && (req_len == '0);

  assign eng_valid = (state == S_XFER);
  assign win_fire  = eng_valid && eng_ready && any_diff;
  assign acc_fire  = eng_valid && eng_ready && !any_diff;
  assign last_acc  = (kind != K_BULK) || (rem == acc_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      kind     <= K_BYTE;
      wr       <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (misaligned) err <= 1'b1;
          else if (empty_bulk) done <= 1'b1;
          else begin
            state    <= S_XFER;
            cur_addr <= req_addr;
            rem      <= req_len;
            kind     <= bpw_kind_e'(req_kind);
            wr       <= req_write;
          end
        end
        S_XFER: if (acc_fire) begin
          if (last_acc) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cur_addr <= cur_addr + 32'(acc_len);
            rem      <= rem - acc_len;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    eng_func = BP_FUNC;
    eng_win  = any_diff;
    if (any_diff) begin
      eng_addr  = WIN_REG_LO + BUS_AW'(pick_idx);
      eng_len   = LEN_W'(1);
      eng_write = 1'b1;
      eng_wdata = pick_val;
    end else begin
      eng_addr  = acc_addr;
      eng_len   = acc_len;
      eng_write = wr;
      eng_wdata = 8'h00;
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !eng_valid); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R9

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_valid); // R11

endmodule

// File: rtl/bpw_window_mgr.sv
module bpw_window_mgr
  import bpw_pkg::*;
#(
  parameter int          WIN_BITS  = 15,
  parameter int          MAX_CHUNK = 64,
  parameter int          LEN_W     = 12,
  parameter logic [31:0] WIN_INIT  = 32'hAAAA_AAAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             eng_valid,
  input  logic             eng_ready,
  output logic [1:0]       eng_func,
  output logic [16:0]      eng_addr,
  output logic [LEN_W-1:0] eng_len,
  output logic             eng_write,
  output logic             eng_win,
  output logic [7:0]       eng_wdata,
  output logic             done,
  output logic             err
);

  localparam int          BUS_AW   = 17;
  localparam int          N_BYTES  = (32 - 8) / 8;
  localparam int          IW       = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam logic [31:0] WIN_SIZE = 32'd1 << WIN_BITS;

  logic [31:0]        cur_addr;
  logic [LEN_W-1:0]   rem;
  bpw_kind_e          kind;
  logic               win_fire, acc_fire, any_diff;
  logic [N_BYTES-1:0] diff;
  logic [IW-1:0]      pick_idx;
  logic [7:0]         pick_val;
  logic [LEN_W-1:0]   acc_len;
  logic [BUS_AW-1:0]  acc_addr;

  bpw_win_regs #(.N_BYTES(N_BYTES), .INIT(WIN_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .target_base(win_base_f(cur_addr, WIN_BITS)),
    .wr_fire(win_fire),
    .diff(diff), .any_diff(any_diff),
    .pick_idx(pick_idx), .pick_val(pick_val)
  );

  bpw_chunk_calc #(.WIN_BITS(WIN_BITS), .MAX_CHUNK(MAX_CHUNK), .LEN_W(LEN_W),
                   .BUS_AW(BUS_AW)) u_chunk (
    .cur_addr(cur_addr), .rem(rem), .kind(kind),
    .acc_len(acc_len), .acc_addr(acc_addr)
  );

  bpw_seq #(.LEN_W(LEN_W), .BUS_AW(BUS_AW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .eng_ready(eng_ready), .any_diff(any_diff), .pick_idx(pick_idx),
    .pick_val(pick_val), .acc_len(acc_len), .acc_addr(acc_addr),
    .cur_addr(cur_addr), .rem(rem), .kind(kind),
    .win_fire(win_fire), .acc_fire(acc_fire),
    .eng_valid(eng_valid), .eng_func(eng_func), .eng_addr(eng_addr),
    .eng_len(eng_len), .eng_write(eng_write), .eng_win(eng_win),
    .eng_wdata(eng_wdata), .done(done), .err(err)
  );

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_addr) && $stable(eng_len)
                                   && $stable(eng_win) && $stable(eng_wdata)
                                   && $stable(eng_write))); // R10

  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_win) |-> (eng_len != '0 && 32'(eng_len) <= 32'(MAX_CHUNK))); // R6

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_win) |->
      (32'(eng_addr[WIN_BITS-1:0]) + 32'(eng_len) <= WIN_SIZE)); // R7

  AST_WIN_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && eng_win) |-> (eng_len == LEN_W'(1) && eng_write)); // R2

endmodule

// File: tb/bpw_window_mgr_test.sv
module bpw_window_mgr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic [11:0] req_len = 12'd0;
  logic        eng_valid;
  logic        eng_ready = 1'b1;
  logic [1:0]  eng_func;
  logic [16:0] eng_addr;
  logic [11:0] eng_len;
  logic        eng_write, eng_win;
  logic [7:0]  eng_wdata;
  logic        done, err;

  always #5 clk = ~clk;

  bpw_window_mgr uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_func(eng_func),
    .eng_addr(eng_addr), .eng_len(eng_len), .eng_write(eng_write),
    .eng_win(eng_win), .eng_wdata(eng_wdata), .done(done), .err(err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] mwin = 32'hAAAA_AAAA;
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_on = 1'b0;
  logic [40:0] exp_q[$];
  logic [40:0] got_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [40:0] pk(input bit w, input bit wr, input logic [16:0] a,
                                     input logic [11:0] l, input logic [7:0] d);
    return {w, wr, 2'd1, a, l, d};
  endfunction

  // expected request list from the requirements (R2..R7)
  task automatic build(input logic [1:0] k, input logic [31:0] a0, input logic [11:0] n,
                       input bit wr);
    logic [31:0] a, r, off, c, base;
    exp_q.delete();
    if (k == 2'd3 && (a0[1:0] != 0 || n == 0)) return;
    a = a0;
    r = (k == 2'd3) ? 32'(n) : (k == 2'd0 ? 1 : (k == 2'd1 ? 2 : 4));
    while (r != 0) begin
      base = {a[31:15], 15'd0};
      for (int i = 2; i >= 0; i--)
        if (mwin[8*(i+1) +: 8] != base[8*(i+1) +: 8]) begin
          exp_q.push_back(pk(1, 1, 17'h1000A + 17'(i), 12'd1, base[8*(i+1) +: 8]));
          mwin[8*(i+1) +: 8] = base[8*(i+1) +: 8];
        end
      off = a % 32'h8000;
      c = r;
      if (c > 64) c = 64;
      if (c > 32'h8000 - off) c = 32'h8000 - off;
      exp_q.push_back(pk(0, wr, 17'(off) | ((k == 2'd2) ? 17'h8000 : 17'h0), 12'(c), 8'h00));
      a = a + c;
      r = r - c;
    end
  endtask

  task automatic run(input logic [1:0] k, input logic [31:0] a, input logic [11:0] n,
                     input bit wr, input string tag);
    bit misal, saw_done, saw_err, busy_ok, fin;
    int cyc;
    misal = (k == 2'd3) && (a[1:0] != 0);
    build(k, a, n, wr);
    got_q.delete();
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = n; req_write = wr;
    saw_done = 0; saw_err = 0; busy_ok = 1; fin = 0; cyc = 0;
    while (!fin) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (eng_valid && eng_ready)
        got_q.push_back({eng_win, eng_write, eng_func, eng_addr, eng_len, eng_wdata});
      if (eng_valid && req_ready) busy_ok = 0;
      if (done) saw_done = 1;
      if (err)  saw_err  = 1;
      if (done || err) fin = 1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      eng_ready = stall_on ? lfsr[0] : 1'b1;
      cyc++;
      if (cyc > 3000) begin
        chk(0, "R9", {tag, " watchdog"}, cyc, 0);
        fin = 1;
      end
    end
    eng_ready = 1'b1;
    chk(saw_err == misal && saw_done == !misal, misal ? "R8" : "R9",
        {tag, " end flag"}, {saw_done, saw_err}, {!misal, misal});
    chk(got_q.size() == exp_q.size(), "R7", {tag, " request count"},
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], "R3", {tag, " request"}, got_q[i], exp_q[i]);
    chk(busy_ok, "R11", {tag, " ready while busy"}, busy_ok, 1);
    @(negedge clk);
    chk(!done && !err, "R9", {tag, " pulse width"}, {done, err}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !eng_valid && !done && !err, "R1", "reset outputs",
        {req_ready, eng_valid, done, err}, 4'b1000);
    rst_n = 1'b1;
    // R1: start value leaves only the low window byte to write
    run(2'd0, 32'hAAAA_C123, 0, 0, "R1 first byte");
    // R2 all three bytes, word flag R5
    run(2'd2, 32'h1800_0004, 0, 1, "R2 word");
    // R3 same window, no writes
    run(2'd1, 32'h1800_4406, 0, 0, "R3 half same window");
    run(2'd0, 32'h1800_8001, 0, 1, "R4 byte next window");
    // R6/R7 bulk across window end
    run(2'd3, 32'h0000_7FC0, 12'd200, 1, "R7 bulk cross");
    run(2'd3, 32'h0000_0100, 12'd64, 0, "R6 bulk exact");
    // R8 misaligned, no traffic, window unchanged
    run(2'd3, 32'h5555_0001, 12'd8, 1, "R8 misal1");
    run(2'd3, 32'h5555_0003, 12'd8, 0, "R8 misal3");
    // R9 zero length
    run(2'd3, 32'h2222_0000, 12'd0, 0, "R9 zero len");
    run(2'd2, 32'h0000_0010, 0, 0, "R5 word after reject");
    // R10 stalled sweep
    stall_on = 1'b1;
    for (int s = 0; s < 24; s++) begin
      logic [31:0] a;
      a = 32'(s) * 32'h0101_8000 + 32'h7F00 + 32'(s % 8) * 32'h20;
      for (int li = 0; li < 8; li++) begin
        logic [11:0] l;
        case (li)
          0: l = 1;   1: l = 3;   2: l = 63;  3: l = 64;
          4: l = 65;  5: l = 127; 6: l = 257; default: l = 300;
        endcase
        run(2'd3, a, l, li[0], "R10 bulk sweep");
      end
      run(2'(s % 3), a + 32'(s), 0, s[0], "R5 single sweep");
    end
    stall_on = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule